// File: doc/BRIEF.md
# Converter Idle Power-Down and Wake Controller

This block decides when the analog front end of a sampling converter is powered. A trigger-driven sequencer asks for acquisitions by pulsing bits of a request vector. Each request is held as a pending bit until it is served. When idle power-down is switched on and nothing is pending, the controller puts the analog into power-down. The next request wakes it and starts a wake-up wait whose length is programmable. A busy flag stays high for the whole of that wait.

When the wait is over, a fixed-priority arbiter chooses among all requests that are pending at that moment. A request that arrived during the wait can therefore be served ahead of the one that caused the wake. Only one acquisition runs at a time. The next choice is made when the done strobe arrives.

A global enable gates both the converter enable and the multiplexer enable. Dropping either the global enable or the converter enable forces power-down, abandons any wait, and discards every pending request.

Top module: `adc_wake_ctrl`

## Requirements
- R1: After reset, `ana_pd` and `mux_pd` are 1, `wake_busy` and `acq_start` are 0, and `grant_idx` is 0.
- R2: The controller runs only while both `glb_en` and `conv_en` are 1. `mux_pd` is 0 only while both `glb_en` and `mux_en` are 1. While the controller is not running, requests are ignored.
- R3: With `idle_pd_en` = 1, the controller is idle when no request is pending and no acquisition is running. While idle, `ana_pd` is 1. After the done strobe of the last pending acquisition, `ana_pd` returns to 1 on the next cycle.
- R4: Suppose a request pulse is latched at clock edge E while the analog is powered down. Then `ana_pd` falls at edge E+1. `wake_busy` is 1 for exactly `wake_dly` cycles. `acq_start` is seen after edge E+`wake_dly`+2, and no start happens while `wake_busy` is 1.
- R5: With `wake_dly` = 0, a wake skips the wait: `wake_busy` never rises, and the start comes after edge E+2.
- R6: `acq_start` is a single-cycle pulse. After a start, no further start happens until `acq_done` is seen. If requests are still pending, the next start follows on the cycle after `acq_done`.
- R7: Requests stay pending until granted. Among pending requests, bit 0 has the highest priority and higher indices have lower priority. `grant_idx` is the binary index of the request that was started, and it holds its value between starts.
- R8: Arbitration is done when the wake-up wait ends. A higher-priority request that arrives during the wait is granted before the request that caused the wake.
- R9: Clearing `glb_en` or `conv_en` forces `ana_pd` to 1 and `wake_busy` to 0 on the next cycle, aborts the wait, and discards all pending requests. No start follows once enables are restored.
- R10: With `idle_pd_en` = 0, the analog stays powered (`ana_pd` = 0) between acquisitions. Enabling the controller powers it up through the wake-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable, gates the other enables |
| conv_en | input | 1 | Converter and sequencer enable |
| mux_en | input | 1 | Input multiplexer enable |
| idle_pd_en | input | 1 | Power down the analog automatically when idle |
| wake_dly | input | DLY_W | Wake-up wait in clock cycles |
| trig_req | input | N_TRIG | Acquisition request pulses, one bit per source |
| acq_done | input | 1 | Strobe marking the end of the running acquisition |
| ana_pd | output | 1 | Converter analog power-down |
| mux_pd | output | 1 | Multiplexer power-down |
| wake_busy | output | 1 | High while the wake-up wait runs |
| grant_idx | output | $clog2(N_TRIG) | Index of the most recently started request |
| acq_start | output | 1 | One-cycle pulse starting an acquisition |

## Verification
The hardest case to reach from the ports is re-arbitration at the end of the wake-up wait. It needs a low-priority request to wake the analog, then a higher-priority request that lands strictly inside the wait window. The bench times this by counting falling edges from the waking pulse. It injects the second request while `wake_busy` is high, then expects the higher-priority grant first and the waking request second, on the cycle after `acq_done`.

Pending sets that hold several requests at once are reached by leaving power-down off with a zero wait and pulsing all of a pattern's bits in one cycle. All fifteen non-empty patterns of the four-source configuration are then drained through done strobes. The wait length is swept over every one of its 256 values.

// File: rtl/adc_wake_pkg.sv
// Shared types for the converter wake controller.
package adc_wake_pkg;

    // Power and activity states of the analog front end.
    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,  // controller disabled, analog powered down
        PS_SLEEP = 3'd1,  // idle power-down, waiting for a request
        PS_WAKE  = 3'd2,  // analog powered, wake-up wait running
        PS_READY = 3'd3,  // analog powered, no acquisition running
        PS_ACQ   = 3'd4   // one acquisition in progress
    } pwr_state_t;

endpackage

// File: rtl/adc_wake_pending.sv
// Sticky pending-request register.
// Each request bit is set by a pulse on the request vector and stays set
// until the same bit is presented on the clear mask. Everything is
// discarded while the controller is not running.
// Assumes: clear mask is one-hot or zero.
module adc_wake_pending #(
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [N_TRIG-1:0] set_vec,
    input  logic [N_TRIG-1:0] clr_vec,
    output logic [N_TRIG-1:0] pend,
    output logic              pend_any
);

    logic [N_TRIG-1:0] pend_q;
    logic [N_TRIG-1:0] pend_d;

    // Next pending set: keep ungranted bits, add new requests, flush when stopped.
    always_comb begin
        if (run) begin
            pend_d = (pend_q & ~clr_vec) | set_vec;
        end else begin
            pend_d = '0;
        end
    end

    // Hold the pending set across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend     = pend_q;
    assign pend_any = |pend_q;

endmodule

// File: rtl/adc_wake_arbiter.sv
// Fixed-priority arbiter, lowest index wins.
// Produces a one-hot grant and its binary index from a request vector.
// Purely combinational; the caller registers whatever it needs.
// Assumes: N_TRIG >= 2.
module adc_wake_arbiter #(
    parameter int N_TRIG = 4,
    localparam int IDX_W = $clog2(N_TRIG)
) (
    input  logic [N_TRIG-1:0] req,
    output logic [N_TRIG-1:0] win_oh,
    output logic [IDX_W-1:0]  win_idx
);

    // blocked[i] is high when any lower index is requesting.
    logic [N_TRIG:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_TRIG; g++) begin : g_prio
            assign blocked[g+1] = blocked[g] | req[g];
            assign win_oh[g]    = req[g] & ~blocked[g];
        end
    endgenerate

    // Encode the one-hot winner as a binary index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (win_oh[i]) begin
                win_idx = win_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_wake_fsm.sv
// Power-state sequencer for the converter analog.
// Steps between disabled, idle power-down, wake-up wait, ready and
// acquiring. It issues a grant whenever it is ready or an acquisition
// finishes and requests are pending. The wait length is sampled when
// the wait starts.
// Assumes: pend_any reflects registered pending state.
module adc_wake_fsm #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle_pd_en,
    input  logic [DLY_W-1:0] wake_dly,
    input  logic             pend_any,
    input  logic             acq_done,
    output logic             issue,
    output logic             ana_pd,
    output logic             wake_busy
);

    import adc_wake_pkg::*;

    pwr_state_t       st_q;
    pwr_state_t       st_d;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] cnt_d;

    // Next state, wait counter and grant request.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        issue = 1'b0;
        if (!run) begin
            st_d = PS_OFF;
        end else begin
            case (st_q)
                PS_OFF: begin
                    if (idle_pd_en) begin
                        st_d = PS_SLEEP;
                    end else if (wake_dly == '0) begin
                        st_d = PS_READY;
                    end else begin
                        st_d  = PS_WAKE;
                        cnt_d = wake_dly - 1'b1;
                    end
                end
                PS_SLEEP: begin
                    if (pend_any) begin
                        if (wake_dly == '0) begin
                            st_d = PS_READY;
                        end else begin
                            st_d  = PS_WAKE;
                            cnt_d = wake_dly - 1'b1;
                        end
                    end
                end
                PS_WAKE: begin
                    if (cnt_q == '0) begin
                        st_d = PS_READY;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                PS_READY: begin
                    if (pend_any) begin
                        issue = 1'b1;
                        st_d  = PS_ACQ;
                    end else if (idle_pd_en) begin
                        st_d = PS_SLEEP;
                    end
                end
                PS_ACQ: begin
                    if (acq_done) begin
                        if (pend_any) begin
                            issue = 1'b1;
                        end else if (idle_pd_en) begin
                            st_d = PS_SLEEP;
                        end else begin
                            st_d = PS_READY;
                        end
                    end
                end
                default: st_d = PS_OFF;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign ana_pd    = (st_q == PS_OFF) || (st_q == PS_SLEEP);
    assign wake_busy = (st_q == PS_WAKE);

endmodule

// File: rtl/adc_wake_ctrl.sv
// Converter idle power-down and wake controller, top level.
// Combines the enable gating, the sticky pending register, the
// fixed-priority arbiter and the power sequencer. It registers the start
// pulse and the granted index.
// Assumes: request bits are pulses; acq_done arrives only while an
// acquisition runs.
module adc_wake_ctrl #(
    parameter int N_TRIG = 4,
    parameter int DLY_W  = 8,
    localparam int IDX_W = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              conv_en,
    input  logic              mux_en,
    input  logic              idle_pd_en,
    input  logic [DLY_W-1:0]  wake_dly,
    input  logic [N_TRIG-1:0] trig_req,
    input  logic              acq_done,
    output logic              ana_pd,
    output logic              mux_pd,
    output logic              wake_busy,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              acq_start
);

    logic              run;
    logic [N_TRIG-1:0] pend;
    logic              pend_any;
    logic [N_TRIG-1:0] win_oh;
    logic [IDX_W-1:0]  win_idx;
    logic              issue;
    logic [N_TRIG-1:0] clr_vec;
    logic              start_q;
    logic [IDX_W-1:0]  grant_q;

    // Local enables only count while the global enable is set.
    assign run    = glb_en & conv_en;
    assign mux_pd = ~(glb_en & mux_en);

    assign clr_vec = issue ? win_oh : '0;

    adc_wake_pending #(.N_TRIG(N_TRIG)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .set_vec  (trig_req),
        .clr_vec  (clr_vec),
        .pend     (pend),
        .pend_any (pend_any)
    );

    adc_wake_arbiter #(.N_TRIG(N_TRIG)) u_arb (
        .req     (pend),
        .win_oh  (win_oh),
        .win_idx (win_idx)
    );

    adc_wake_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .idle_pd_en (idle_pd_en),
        .wake_dly   (wake_dly),
        .pend_any   (pend_any),
        .acq_done   (acq_done),
        .issue      (issue),
        .ana_pd     (ana_pd),
        .wake_busy  (wake_busy)
    );

    // Register the start pulse and latch the winner on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            grant_q <= '0;
        end else begin
            start_q <= issue;
            if (issue) begin
                grant_q <= win_idx;
            end
        end
    end

    assign acq_start = start_q;
    assign grant_idx = grant_q;

endmodule

// File: rtl/adc_wake_ctrl_chk.sv
// Temporal checks on the wake controller ports, bound to every instance.
module adc_wake_ctrl_chk #(
    parameter int N_TRIG = 4,
    localparam int IDX_W = $clog2(N_TRIG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             conv_en,
    input logic             acq_done,
    input logic             ana_pd,
    input logic             wake_busy,
    input logic             acq_start,
    input logic [IDX_W-1:0] grant_idx
);

    // No start while the wake-up wait runs (R4).
    p_no_start_in_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> !acq_start);

    // The analog is powered whenever the wait runs (R4).
    p_wait_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> !ana_pd);

    // A start without a done strobe is followed by no start (R6).
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && !acq_done) |=> !acq_start);

    // The grant index moves only together with a start (R7).
    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_start |-> $stable(grant_idx));

    // Disabling forces power-down and stops activity next cycle (R9).
    p_disable_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en && conv_en) |=> (ana_pd && !wake_busy && !acq_start));

    // No acquisition starts while powered down (R3).
    p_pd_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ana_pd |-> !acq_start);

endmodule

bind adc_wake_ctrl adc_wake_ctrl_chk #(.N_TRIG(N_TRIG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .conv_en   (conv_en),
    .acq_done  (acq_done),
    .ana_pd    (ana_pd),
    .wake_busy (wake_busy),
    .acq_start (acq_start),
    .grant_idx (grant_idx)
);

// File: tb/adc_wake_ctrl_tb_top.sv
// Self-checking bench: sweeps every wait length, every pending pattern,
// re-arbitration during the wait, disable flush and enable gating.
module adc_wake_ctrl_tb_top;

    localparam int NT = 4;
    localparam int DW = 8;
    localparam int IW = $clog2(NT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en = 1'b0;
    logic          conv_en = 1'b0;
    logic          mux_en = 1'b0;
    logic          idle_pd_en = 1'b0;
    logic [DW-1:0] wake_dly = '0;
    logic [NT-1:0] trig_req = '0;
    logic          acq_done = 1'b0;
    logic          ana_pd;
    logic          mux_pd;
    logic          wake_busy;
    logic [IW-1:0] grant_idx;
    logic          acq_start;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_wake_ctrl #(.N_TRIG(NT), .DLY_W(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_en     (glb_en),
        .conv_en    (conv_en),
        .mux_en     (mux_en),
        .idle_pd_en (idle_pd_en),
        .wake_dly   (wake_dly),
        .trig_req   (trig_req),
        .acq_done   (acq_done),
        .ana_pd     (ana_pd),
        .mux_pd     (mux_pd),
        .wake_busy  (wake_busy),
        .grant_idx  (grant_idx),
        .acq_start  (acq_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Pulse a request vector for one cycle.
    task automatic pulse(input logic [NT-1:0] v);
        trig_req = v;
        @(negedge clk);
        trig_req = '0;
    endtask

    // Pulse the done strobe for one cycle.
    task automatic done_pulse();
        acq_done = 1'b1;
        @(negedge clk);
        acq_done = 1'b0;
    endtask

    // Wait for a start pulse; returns the number of cycles waited.
    task automatic wait_start(input int lim, output int n);
        n = 0;
        while (!acq_start && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int n;
        int busy_n;
        bit pd1;

        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset values
        chk(ana_pd == 1'b1, "R1 ana_pd", int'(ana_pd), 1);
        chk(mux_pd == 1'b1, "R1 mux_pd", int'(mux_pd), 1);
        chk(wake_busy == 1'b0, "R1 wake_busy", int'(wake_busy), 0);
        chk(acq_start == 1'b0, "R1 acq_start", int'(acq_start), 0);
        chk(grant_idx == '0, "R1 grant_idx", int'(grant_idx), 0);

        // R2: multiplexer enable gated by global enable
        mux_en = 1'b1;
        cyc(1);
        chk(mux_pd == 1'b1, "R2 mux gated off", int'(mux_pd), 1);
        glb_en = 1'b1;
        cyc(1);
        chk(mux_pd == 1'b0, "R2 mux on", int'(mux_pd), 0);
        mux_en = 1'b0;
        cyc(1);
        chk(mux_pd == 1'b1, "R2 mux off", int'(mux_pd), 1);

        // R2: converter enable without global enable ignores requests
        glb_en = 1'b0;
        conv_en = 1'b1;
        idle_pd_en = 1'b1;
        pulse(4'b0001);
        cyc(5);
        chk(ana_pd == 1'b1, "R2 ignored ana_pd", int'(ana_pd), 1);
        glb_en = 1'b1;
        cyc(10);
        chk(ana_pd == 1'b1, "R2 ignored request flushed", int'(ana_pd), 1);
        chk(acq_start == 1'b0, "R2 no start", int'(acq_start), 0);

        // R3: idle with power-down enabled stays powered down
        chk(wake_busy == 1'b0, "R3 idle busy", int'(wake_busy), 0);

        // R4/R5: sweep every wait length from sleep
        for (int d = 0; d < (1 << DW); d++) begin
            wake_dly = DW'(d);
            pulse(NT'(1) << (d % NT));
            n = 0;
            busy_n = 0;
            pd1 = 1'b1;
            while (!acq_start && n < 400) begin
                @(negedge clk);
                n++;
                if (wake_busy) busy_n++;
                if (n == 1) pd1 = ana_pd;
            end
            chk(n == d + 2, (d == 0) ? "R5 latency" : "R4 latency", n, d + 2);
            chk(busy_n == d, (d == 0) ? "R5 busy length" : "R4 busy length", busy_n, d);
            chk(pd1 == 1'b0, "R4 power up", int'(pd1), 0);
            chk(grant_idx == IW'(d % NT), "R7 grant", int'(grant_idx), d % NT);
            @(negedge clk);
            chk(acq_start == 1'b0, "R6 single pulse", int'(acq_start), 0);
            done_pulse();
            chk(ana_pd == 1'b1, "R3 back to sleep", int'(ana_pd), 1);
        end

        // R8: higher-priority request during the wait is served first
        wake_dly = 8'd5;
        pulse(4'b1000);
        cyc(1);
        chk(wake_busy == 1'b1, "R8 in wait", int'(wake_busy), 1);
        pulse(4'b0010);
        wait_start(20, n);
        chk(acq_start == 1'b1, "R8 start", int'(acq_start), 1);
        chk(grant_idx == 2'd1, "R8 first grant", int'(grant_idx), 1);
        cyc(3);
        chk(acq_start == 1'b0, "R6 held until done", int'(acq_start), 0);
        done_pulse();
        chk(acq_start == 1'b1, "R6 regrant after done", int'(acq_start), 1);
        chk(grant_idx == 2'd3, "R8 waking request second", int'(grant_idx), 3);
        @(negedge clk);
        done_pulse();
        chk(ana_pd == 1'b1, "R3 sleep after drain", int'(ana_pd), 1);

        // R9: disabling during the wait flushes everything
        wake_dly = 8'd10;
        pulse(4'b0100);
        cyc(2);
        chk(wake_busy == 1'b1, "R9 in wait", int'(wake_busy), 1);
        conv_en = 1'b0;
        pulse(4'b0001);
        chk(ana_pd == 1'b1, "R9 forced pd", int'(ana_pd), 1);
        chk(wake_busy == 1'b0, "R9 wait aborted", int'(wake_busy), 0);
        conv_en = 1'b1;
        n = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (acq_start || wake_busy) n++;
        end
        chk(n == 0, "R9 no activity after flush", n, 0);
        chk(ana_pd == 1'b1, "R9 stays powered down", int'(ana_pd), 1);

        // R10/R7: power-down off, zero wait, every pending pattern
        idle_pd_en = 1'b0;
        wake_dly = '0;
        conv_en = 1'b0;
        cyc(1);
        conv_en = 1'b1;
        cyc(2);
        chk(ana_pd == 1'b0, "R10 powered when enabled", int'(ana_pd), 0);
        for (int p = 1; p < (1 << NT); p++) begin
            pulse(NT'(p));
            for (int b = 0; b < NT; b++) begin
                if (p[b]) begin
                    wait_start(10, n);
                    chk(acq_start == 1'b1, "R7 start", int'(acq_start), 1);
                    chk(grant_idx == IW'(b), "R7 priority order", int'(grant_idx), b);
                    @(negedge clk);
                    done_pulse();
                end
            end
            cyc(3);
            chk(acq_start == 1'b0, "R7 drained", int'(acq_start), 0);
            chk(ana_pd == 1'b0, "R10 stays powered", int'(ana_pd), 0);
        end

        // R10: enabling with power-down off goes through the wait
        wake_dly = 8'd4;
        conv_en = 1'b0;
        cyc(1);
        conv_en = 1'b1;
        busy_n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (wake_busy) busy_n++;
        end
        chk(busy_n == 4, "R10 enable wait", busy_n, 4);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule